// File: doc/BRIEF.md
# LDPC parity accumulator core

This block builds the parity part of a systematic LDPC code word. Information words of N bits arrive on an input stream. A second stream supplies, for every information bit in turn, the parity positions that the bit feeds. The block forwards each information word unchanged to the output. It also breaks the word into single bits, one per accepted offset. Every bit of value one is XORed into a 16-bit-wide parity store at each of its positions.

The store has a two-cycle read-modify-write path. Back-to-back updates that hit the same word are resolved by forwarding the two pending write values. When the final bit of the frame has retired, the block reads the store back in ascending order. During that readout it applies the running XOR along the parity bits and clears each word for the next frame. The 16-bit words go out as N-bit chunks after the data, and the last of these chunks carries the end-of-frame flag.

Top module: `ldpc_parity_accum`

## Requirements
- R1: Each accepted input word appears unchanged on the output with out_last low, and its bits are serialized bit 0 first.
- R2: An information bit of value one toggles parity bit p at each offset p given for it, where offset bits 15:4 select the 16-bit store word and bits 3:0 the bit inside it. A bit of value zero leaves the parity unchanged. Offsets must be below PAR_BITS.
- R3: An offset is accepted only while a serialized bit is pending, so off_ready is low otherwise. The pending bit retires on an accepted offset that has off_next high.
- R4: in_ready is high only when no bit is pending, no readout is running and out_ready is high. After the final bit of a frame retires, in_ready is low until the parity has been sent.
- R5: Updates that hit the same store word one or two cycles apart accumulate correctly, and two hits on the same bit cancel.
- R6: The parity that is sent is the running XOR of the accumulated bits in ascending order: final p[i] equals acc p[i] XOR final p[i-1], with final p[0] equal to acc p[0].
- R7: The parity follows the frame's data as PAR_BITS/N chunks. Store words go in ascending order and the low chunk of a word goes first, so chunk k carries parity bits k*N to k*N+N-1. out_last is high on the final chunk only.
- R8: The store is cleared during readout, so each frame's parity depends only on that frame's bits and offsets.
- R9: After reset, out_valid and off_ready are low and the store holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DW | Information word |
| in_valid | input | 1 | Information word valid |
| in_last | input | 1 | Final word of the frame |
| in_ready | output | 1 | Information word accepted |
| off_data | input | 16 | Parity bit position for the pending bit |
| off_next | input | 1 | Final offset of the pending bit |
| off_valid | input | 1 | Offset valid |
| off_ready | output | 1 | Offset accepted |
| out_data | output | DW | Forwarded data or parity chunk |
| out_valid | output | 1 | Output valid |
| out_last | output | 1 | Final parity chunk of the frame |
| out_ready | input | 1 | Downstream accepts output |

## Verification
A lost or stale forwarded write in the update pipeline leaves no trace while the frame is arriving. It shows up only after the frame has ended, as wrong parity chunks, and the running XOR spreads the error into every later parity bit. A store that is not cleared does not hurt the first frame. It corrupts the next frame's parity, which shows one whole frame later. For these reasons the bench sends offsets back to back to provoke one- and two-cycle hazards. It also compares every output beat against a model that keeps its parity as a plain bit vector, over several frames in a row.

// File: rtl/ldpc_acc_pkg.sv
package ldpc_acc_pkg;

  typedef enum logic [1:0] {RO_IDLE, RO_REQ, RO_WAIT, RO_EMIT} ro_state_t;

  // running XOR over a 16-bit word, seeded with the bit just below it
  function automatic logic [15:0] chain_xor16(input logic [15:0] w, input logic cin);
    logic [15:0] r;
    logic c;
    c = cin;
    for (int i = 0; i < 16; i++) begin
      c    = c ^ w[i];
      r[i] = c;
    end
    return r;
  endfunction

  // single-bit toggle mask inside a store word
  function automatic logic [15:0] bit_mask(input logic [3:0] pos);
    return 16'(1) << pos;
  endfunction

endpackage

// File: rtl/ldpc_bit_serializer.sv
module ldpc_bit_serializer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          load_last,
  input  logic          advance,
  output logic          has_bit,
  output logic          cur_bit,
  output logic          final_bit
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sh;
  logic [IW-1:0] idx;
  logic          full;
  logic          lst;
  logic          at_end;

  assign at_end    = (idx == IW'(DW - 1));
  assign has_bit   = full;
  assign cur_bit   = sh[0];
  assign final_bit = full & lst & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      idx  <= '0;
      full <= 1'b0;
      lst  <= 1'b0;
    end else if (load) begin
      sh   <= load_data;
      idx  <= '0;
      full <= 1'b1;
      lst  <= load_last;
    end else if (advance && full) begin
      if (at_end) begin
        full <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
        sh  <= sh >> 1;
      end
    end
  end

  // R1: a new word is taken only once the previous one is fully serialized
  a_r1_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full);

endmodule

// File: rtl/ldpc_parity_ram.sv
module ldpc_parity_ram #(
  parameter int WORDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [AW-1:0]       acc_addr,
  input  logic [15:0]         acc_mask,
  input  logic                ro_valid,
  input  logic [AW-1:0]       ro_addr,
  output logic                ro_data_valid,
  output logic [15:0]         ro_data
);
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1;

  typedef struct packed {
    logic          v;
    logic          clr;
    logic [AW-1:0] addr;
    logic [15:0]   mask;
  } op_t;

  typedef struct packed {
    logic          v;
    logic [AW-1:0] addr;
    logic [15:0]   data;
  } wr_t;

  logic [15:0] mem [WORDS];
  op_t         s0, s1, s2;
  logic [15:0] rd1, rd2;
  wr_t         h1, h2;
  logic [15:0] merged, wdata;
  logic        fwd_near, fwd_far;

  always_comb begin
    s0.v    = acc_valid | ro_valid;
    s0.clr  = ro_valid;
    s0.addr = ro_valid ? ro_addr : acc_addr;
    s0.mask = ro_valid ? 16'h0 : acc_mask;
  end

  // forwarding: h1 is the write from the previous cycle, h2 the one before
  assign fwd_near = h1.v && (h1.addr == s2.addr);
  assign fwd_far  = h2.v && (h2.addr == s2.addr);

  always_comb begin
    merged = rd2;
    if (fwd_far)  merged = h2.data;
    if (fwd_near) merged = h1.data;
  end

  assign wdata         = s2.clr ? 16'h0 : (merged ^ s2.mask);
  assign ro_data_valid = s2.v & s2.clr;
  assign ro_data       = merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      s1  <= '0;
      s2  <= '0;
      rd1 <= '0;
      rd2 <= '0;
      h1  <= '0;
      h2  <= '0;
    end else begin
      s1  <= s0;
      s2  <= s1;
      rd1 <= mem[s0.addr];
      rd2 <= rd1;
      if (s2.v) mem[s2.addr] <= wdata;
      h1  <= '{v: s2.v, addr: s2.addr, data: wdata};
      h2  <= h1;
    end
  end

  // R5: updates and readout never compete for the pipeline
  a_r5_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && ro_valid));

endmodule

// File: rtl/ldpc_readout.sv
module ldpc_readout
  import ldpc_acc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          ro_req,
  output logic [AW-1:0] ro_addr,
  input  logic          ro_data_valid,
  input  logic [15:0]   ro_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_last,
  input  logic          out_ready
);
  localparam int AW  = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CK  = 16 / DW;
  localparam int CKW = (CK > 1) ? $clog2(CK) : 1;

  ro_state_t      st;
  logic [AW-1:0]  wc;
  logic [CKW-1:0] ck;
  logic [15:0]    word;
  logic           carry;
  logic [15:0]    chained;
  logic           last_chunk, last_word;

  assign chained    = chain_xor16(ro_data, carry);
  assign last_chunk = (ck == CKW'(CK - 1));
  assign last_word  = (wc == AW'(WORDS - 1));
  assign busy       = (st != RO_IDLE);
  assign ro_req     = (st == RO_REQ);
  assign ro_addr    = wc;
  assign out_valid  = (st == RO_EMIT);
  assign out_data   = DW'(word >> (ck * DW));
  assign out_last   = out_valid & last_chunk & last_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= RO_IDLE;
      wc    <= '0;
      ck    <= '0;
      word  <= '0;
      carry <= 1'b0;
    end else begin
      case (st)
        RO_IDLE: if (start) begin
          st    <= RO_REQ;
          wc    <= '0;
          carry <= 1'b0;
        end
        RO_REQ: st <= RO_WAIT;
        RO_WAIT: if (ro_data_valid) begin
          word  <= chained;
          carry <= chained[15];
          ck    <= '0;
          st    <= RO_EMIT;
        end
        RO_EMIT: if (out_ready) begin
          if (last_chunk) begin
            if (last_word) begin
              st <= RO_IDLE;
            end else begin
              wc <= wc + 1'b1;
              st <= RO_REQ;
            end
          end else begin
            ck <= ck + 1'b1;
          end
        end
        default: st <= RO_IDLE;
      endcase
    end
  end

  // R7: store words return only while the readout waits for one
  a_r7_data_when_awaited: assert property (@(posedge clk) disable iff (!rst_n)
    ro_data_valid |-> (st == RO_WAIT));

endmodule

// File: rtl/ldpc_parity_accum.sv
module ldpc_parity_accum
  import ldpc_acc_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PAR_BITS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  input  logic [15:0]   off_data,
  input  logic          off_next,
  input  logic          off_valid,
  output logic          off_ready,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_last,
  input  logic          out_ready
);
  localparam int WORDS = PAR_BITS / 16;
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic          has_bit, cur_bit, final_bit;
  logic          ser_load, off_fire, acc_hit, bit_done, frame_done;
  logic          ro_busy, ro_req, ro_data_valid;
  logic [AW-1:0] ro_addr, acc_addr;
  logic [15:0]   ro_data, acc_mask;
  logic [DW-1:0] ro_out_data;
  logic          ro_out_valid, ro_out_last;

  assign in_ready   = ~ro_busy & ~has_bit & out_ready;
  assign ser_load   = in_valid & in_ready;
  assign off_ready  = ~ro_busy & has_bit;
  assign off_fire   = off_valid & off_ready;
  assign acc_hit    = off_fire & cur_bit;
  assign bit_done   = off_fire & off_next;
  assign frame_done = bit_done & final_bit;
  assign acc_addr   = off_data[4 +: AW];
  assign acc_mask   = bit_mask(off_data[3:0]);

  ldpc_bit_serializer #(.DW(DW)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ser_load),
    .load_data (in_data),
    .load_last (in_last),
    .advance   (bit_done),
    .has_bit   (has_bit),
    .cur_bit   (cur_bit),
    .final_bit (final_bit)
  );

  ldpc_parity_ram #(.WORDS(WORDS)) u_ram (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_hit),
    .acc_addr      (acc_addr),
    .acc_mask      (acc_mask),
    .ro_valid      (ro_req),
    .ro_addr       (ro_addr),
    .ro_data_valid (ro_data_valid),
    .ro_data       (ro_data)
  );

  ldpc_readout #(.DW(DW), .WORDS(WORDS)) u_ro (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (frame_done),
    .busy          (ro_busy),
    .ro_req        (ro_req),
    .ro_addr       (ro_addr),
    .ro_data_valid (ro_data_valid),
    .ro_data       (ro_data),
    .out_data      (ro_out_data),
    .out_valid     (ro_out_valid),
    .out_last      (ro_out_last),
    .out_ready     (out_ready)
  );

  // output mux: data pass-through while accumulating, parity during readout
  always_comb begin
    if (ro_busy) begin
      out_data  = ro_out_data;
      out_valid = ro_out_valid;
      out_last  = ro_out_last;
    end else begin
      out_data  = in_data;
      out_valid = in_valid & ~has_bit;
      out_last  = 1'b0;
    end
  end

  // R4: input closes once the frame's final bit retires
  a_r4_closed_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !in_ready);

  // R3: offsets and new words are never both accepted
  a_r3_off_excludes_input: assert property (@(posedge clk) disable iff (!rst_n)
    off_ready |-> !in_ready);

  // R7: the final parity chunk hands the input back
  a_r7_last_reopens_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && out_ready) |=> (in_ready == out_ready));

  // R2: offsets stay inside the parity store
  a_r2_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |-> (32'(off_data[15:4]) < WORDS));

endmodule

// File: tb/test_ldpc_parity_accum.sv
module test_ldpc_parity_accum;
  localparam int DW = 8;
  localparam int PB = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [15:0]   off_data = '0;
  logic          off_next = 1'b0, off_valid = 1'b0, off_ready;
  logic [DW-1:0] out_data;
  logic          out_valid, out_last;
  logic          out_ready = 1'b1;

  int total = 0, bad = 0, cyc = 0;
  logic in_fire_s = 1'b0, off_fire_s = 1'b0;

  logic [DW-1:0] exp_d[$];
  logic          exp_l[$];
  logic          exp_p[$];
  string         exp_t[$];

  always #4 clk = ~clk;

  ldpc_parity_accum #(.DW(DW), .PAR_BITS(PB)) i_ldpc_parity_accum (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .off_data(off_data), .off_next(off_next), .off_valid(off_valid), .off_ready(off_ready),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "WATCHDOG", "run hung", 32'(cyc), 32'd150000);
      summary();
    end
  end

  always @(negedge clk) if (rst_n) out_ready = ($urandom % 4) != 0;

  // sample one time unit before the rising edge
  always @(negedge clk) begin
    #3;
    in_fire_s  = in_valid & in_ready;
    off_fire_s = off_valid & off_ready;
    if (rst_n) begin
      if (exp_p.size() > 0 && exp_p[0]) begin
        chk(in_ready == 1'b0, "R4", "in_ready during parity", 32'(in_ready), 0);
        if (out_valid)
          chk(off_ready == 1'b0, "R3", "off_ready during readout", 32'(off_ready), 0);
      end
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R7", "unexpected output beat", 32'(out_data), 0);
        end else begin
          chk(out_data == exp_d[0], exp_t[0], "output data", 32'(out_data), 32'(exp_d[0]));
          chk(out_last == exp_l[0], "R7", "output last", 32'(out_last), 32'(exp_l[0]));
          void'(exp_d.pop_front()); void'(exp_l.pop_front());
          void'(exp_p.pop_front()); void'(exp_t.pop_front());
        end
      end
    end
  end

  task automatic send_word(input logic [DW-1:0] d, input logic l);
    in_valid = 1'b1; in_data = d; in_last = l;
    do @(posedge clk); while (!in_fire_s);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_off(input logic [15:0] o, input logic nx);
    off_valid = 1'b1; off_data = o; off_next = nx;
    do @(posedge clk); while (!off_fire_s);
    @(negedge clk);
  endtask

  // mode 0: random, 1: all-ones data with clustered offsets, 2: all-zero data
  task automatic run_frame(input int mode, input int nwords, input string tag);
    logic [DW-1:0] words[$];
    int            offs[$];
    logic          nxt[$];
    logic [PB-1:0] par;
    par = '0;
    for (int w = 0; w < nwords; w++) begin
      logic [DW-1:0] d;
      d = (mode == 1) ? '1 : (mode == 2) ? '0 : DW'($urandom);
      words.push_back(d);
      exp_d.push_back(d); exp_l.push_back(1'b0); exp_p.push_back(1'b0); exp_t.push_back("R1");
      for (int b = 0; b < DW; b++) begin
        int k, n, base;
        k = w * DW + b;
        n = 1 + int'($urandom % 3);
        base = (k * 3) % PB;
        for (int t = 0; t < n; t++) begin
          int o;
          if (mode == 1) o = (t == 1) ? (base ^ 1) : base;
          else o = int'($urandom % PB);
          offs.push_back(o);
          nxt.push_back(t == n - 1);
          if (d[b]) par[o] = ~par[o];
        end
      end
    end
    for (int i = 1; i < PB; i++) par[i] = par[i] ^ par[i-1];
    for (int c = 0; c < PB / DW; c++) begin
      exp_d.push_back(par[c*DW +: DW]);
      exp_l.push_back(c == PB / DW - 1);
      exp_p.push_back(1'b1);
      exp_t.push_back(tag);
    end
    @(negedge clk);
    fork
      begin
        foreach (words[i]) begin
          if ($urandom % 4 == 0) @(negedge clk);
          send_word(words[i], i == nwords - 1);
        end
      end
      begin
        foreach (offs[i]) begin
          if (mode == 0 && $urandom % 6 == 0) begin
            off_valid = 1'b0;
            @(negedge clk);
          end
          send_off(16'(offs[i]), nxt[i]);
        end
        off_valid = 1'b0;
      end
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(out_valid == 1'b0, "R9", "out_valid after reset", 32'(out_valid), 0);
    chk(off_ready == 1'b0, "R3", "off_ready with no bit", 32'(off_ready), 0);
    chk(in_ready == 1'b1, "R4", "in_ready after reset", 32'(in_ready), 1);
    run_frame(2, 3, "R2");   // zero bits leave parity zero; store clean after reset (R9)
    run_frame(1, 4, "R5");   // same-word hits back to back, cancelling pairs
    run_frame(0, 3, "R6");   // random bits, running XOR
    run_frame(0, 2, "R8");   // store cleared between frames
    run_frame(0, 5, "R7");   // longer frame, chunk order and last
    while (exp_d.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end

endmodule